// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a bank of free-running 32-bit event counters on a simple single-cycle register port. Each counter has an 8-bit selector that ties it to one line of an 8-line event pulse vector. A counter advances by one on each clock edge in which its selected line is high, provided the bank-wide run bit and the counter's own enable bit are both set. Enable and interrupt-enable masks are changed through separate set and clear addresses, so software never has to read, modify and write them.

Two features let software leave counters running without reloading them. First, an odd counter can be chained to the even counter below it, so that the pair forms one 64-bit counter. Second, each counter can flag overflow on every toggle of its top bit, in either direction, instead of only when it wraps. Overflow flags gather into a write-1-to-clear status register. A single interrupt line is raised while any flagged counter also has its interrupt enabled.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter value, event selector, mask register and overflow flag is zero, and `irq` is low.
- R2: A read presented with `bus_rd` at a clock edge puts its data on `bus_rdata` at that edge. Counter n's value sits at 0x420+8n and its selector at 0x220+8n. The per-counter control slots at 0x120+8n, any misaligned offset and every other unmapped address read zero.
- R3: Selector code 0x01 picks line 0 (cycles), and codes 0x20 to 0x26 pick lines 1 to 7 in order. Any other code, 0 included, counts nothing.
- R4: A counter advances by exactly one in a cycle where its selected line is high, its enable bit is set and bit 0 of the control register at 0x500 is set. When either enable is clear it holds its value.
- R5: Writing 1s to 0x508 or 0x50C sets or clears those bits of the counter-enable mask. Writing 1s to 0x510 or 0x514 does the same for the interrupt-enable mask. Bit n is counter n, and both addresses of a pair read back the current mask.
- R6: With its toggle option off, a counter sets its overflow flag (bit n of 0x740) only when it wraps from all ones to zero. Crossing from 0x7FFFFFFF to 0x80000000 does not set the flag.
- R7: With bit n of 0x96C set, counter n sets its overflow flag on every change of its bit 31, on both the rising and the falling transition.
- R8: Writing 1 to bit n of 0x740 clears flag n. A new overflow in the same cycle wins over the clear.
- R9: `irq` is high exactly while some counter has both its overflow flag and its interrupt-enable bit set.
- R10: Setting odd bit n of the gang register at 0x718 makes counter n advance once per wrap of counter n-1, in the same edge, instead of on its own event. Even bits are ignored and read back as zero.
- R11: A write to a counter's value address loads that value, and it overrides any increment in the same cycle.
- R12: Writing 0x500 with bit 1 set zeroes all counter values. Bit 1 always reads back as zero, and bit 0 takes the written run value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe, data registered at the clock edge |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held until the next read |
| evt_in | input | 8 | Event pulse lines, line 0 is cycles |
| irq | output | 1 | Overflow interrupt |

## Verification
A register write takes effect at the edge where the strobe is sampled, and an event pulse moves its counter at that same edge. A chained upper counter also moves in the very edge in which its lower half wraps. Overflow flags and `irq` settle together at that edge, while read data appears one edge after `bus_rd` is presented. The bench drives every input at the falling edge. It checks `irq` directly at the next falling edge, and its monitor pops each queued read expectation at the falling edge that follows the read strobe's clock edge. The corner cases (set-versus-clear on the status register, a software load racing an event, and a chain carry) are each driven within one cycle, so that the two actions meet at the same edge.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
   localparam int ADR_VAL_BASE = 'h420;
   localparam int ADR_SEL_BASE = 'h220;
   localparam int ADR_STRIDE   = 8;
   localparam int ADR_RUN      = 'h500;
   localparam int ADR_EN_SET   = 'h508;
   localparam int ADR_EN_CLR   = 'h50C;
   localparam int ADR_IE_SET   = 'h510;
   localparam int ADR_IE_CLR   = 'h514;
   localparam int ADR_GANG     = 'h718;
   localparam int ADR_OVF      = 'h740;
   localparam int ADR_MSB      = 'h96C;

   localparam int CODE_CYCLES  = 'h01;
   localparam int CODE_FIRST   = 'h20;

   // mask with the odd bit positions set, used to keep only chainable gang bits
   function automatic logic [31:0] odd_bits(input int n);
      logic [31:0] m;
      m = '0;
      for (int i = 1; i < n; i += 2) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/cbank_evt_sel.sv
module cbank_evt_sel #(
   parameter int EVT_W = 8,
   parameter int SEL_W = 8
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [EVT_W-1:0] evt_in,
   output logic             hit
);
   import cbank_pkg::*;

   // R3: 0x01 -> line 0, 0x20.. -> lines 1.., anything else counts nothing
   always_comb begin
      hit = 1'b0;
      if (sel == SEL_W'(CODE_CYCLES)) hit = evt_in[0];
      for (int i = 1; i < EVT_W; i++) begin
         if (sel == SEL_W'(CODE_FIRST + i - 1)) hit = evt_in[i];
      end
   end
endmodule

// File: rtl/cbank_counter.sv
module cbank_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             evt_hit,
   input  logic             chain_en,
   input  logic             carry_in,
   input  logic             sw_wr,
   input  logic [CNT_W-1:0] sw_data,
   input  logic             clr_all,
   input  logic             msb_mode,
   output logic [CNT_W-1:0] value,
   output logic             carry_out,
   output logic             ovf_evt
);
   localparam int TOP = CNT_W - 1;

   logic             step;
   logic [CNT_W-1:0] nxt;

   assign step      = run && !sw_wr && !clr_all && (chain_en ? carry_in : evt_hit);
   assign nxt       = value + 1'b1;
   assign carry_out = step && (&value);
   assign ovf_evt   = msb_mode ? (step && (value[TOP] != nxt[TOP])) : carry_out;

   always_ff @(posedge clk) begin
      if (!rst_n)       value <= '0;
      else if (clr_all) value <= '0;
      else if (sw_wr)   value <= sw_data;
      else if (step)    value <= nxt;
   end

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && !clr_all) |=> (value == $past(value) || value == $past(value) + 1'b1));

   a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !sw_wr && !clr_all) |=> $stable(value));

   a_r11_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !clr_all) |=> value == $past(sw_data));

   a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |=> value == '0);

   a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> value == '0);
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 32,
   parameter int SEL_W   = 8,
   parameter int EVT_W   = 8,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EVT_W-1:0]  evt_in,
   output logic              irq
);
   import cbank_pkg::*;

   localparam logic [NUM_CNT-1:0] GANG_OK = NUM_CNT'(odd_bits(NUM_CNT));

   if (NUM_CNT < 2 || NUM_CNT > 8 || (NUM_CNT % 2) != 0) begin : g_bad_num
      $error("NUM_CNT must be an even count from 2 to 8");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_width
      $error("CNT_W must fit the data bus");
   end
   if (EVT_W < 2 || SEL_W < 8 || SEL_W > DATA_W) begin : g_bad_evt
      $error("event or selector width out of range");
   end

   logic               run_q;
   logic [NUM_CNT-1:0] en_q, ie_q, gang_q, msb_q, ovf_q;
   logic [SEL_W-1:0]   sel_q   [NUM_CNT];
   logic [CNT_W-1:0]   cval    [NUM_CNT];
   logic [NUM_CNT-1:0] carry, ovf_evt, hit, val_wr;
   logic               clr_all;
   logic [DATA_W-1:0]  rd_mux;

   function automatic logic wr_at(input int adr);
      return bus_wr && (bus_addr == ADDR_W'(adr));
   endfunction

   assign clr_all = wr_at(ADR_RUN) && bus_wdata[1];

   // shared control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         en_q   <= '0;
         ie_q   <= '0;
         gang_q <= '0;
         msb_q  <= '0;
      end else begin
         if (wr_at(ADR_RUN))    run_q  <= bus_wdata[0];
         if (wr_at(ADR_EN_SET)) en_q   <= en_q | bus_wdata[NUM_CNT-1:0];
         if (wr_at(ADR_EN_CLR)) en_q   <= en_q & ~bus_wdata[NUM_CNT-1:0];
         if (wr_at(ADR_IE_SET)) ie_q   <= ie_q | bus_wdata[NUM_CNT-1:0];
         if (wr_at(ADR_IE_CLR)) ie_q   <= ie_q & ~bus_wdata[NUM_CNT-1:0];
         if (wr_at(ADR_GANG))   gang_q <= bus_wdata[NUM_CNT-1:0] & GANG_OK;
         if (wr_at(ADR_MSB))    msb_q  <= bus_wdata[NUM_CNT-1:0];
      end
   end

   // overflow status: hardware set wins over software write-1-to-clear
   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= '0;
      else if (wr_at(ADR_OVF)) ovf_q <= (ovf_q & ~bus_wdata[NUM_CNT-1:0]) | ovf_evt;
      else ovf_q <= ovf_q | ovf_evt;
   end

   assign irq = |(ovf_q & ie_q);

   for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
      localparam int VAL_ADR = ADR_VAL_BASE + ADR_STRIDE * n;
      localparam int SEL_ADR = ADR_SEL_BASE + ADR_STRIDE * n;

      logic chain_en, carry_in;

      assign val_wr[n] = wr_at(VAL_ADR);

      always_ff @(posedge clk) begin
         if (!rst_n)           sel_q[n] <= '0;
         else if (wr_at(SEL_ADR)) sel_q[n] <= bus_wdata[SEL_W-1:0];
      end

      cbank_evt_sel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) i_sel (
         .sel    (sel_q[n]),
         .evt_in (evt_in),
         .hit    (hit[n])
      );

      if ((n % 2) == 1) begin : g_upper
         assign chain_en = gang_q[n];
         assign carry_in = carry[n-1];
      end else begin : g_lower
         assign chain_en = 1'b0;
         assign carry_in = 1'b0;
      end

      cbank_counter #(.CNT_W(CNT_W)) i_ctr (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run_q && en_q[n]),
         .evt_hit   (hit[n]),
         .chain_en  (chain_en),
         .carry_in  (carry_in),
         .sw_wr     (val_wr[n]),
         .sw_data   (bus_wdata[CNT_W-1:0]),
         .clr_all   (clr_all),
         .msb_mode  (msb_q[n]),
         .value     (cval[n]),
         .carry_out (carry[n]),
         .ovf_evt   (ovf_evt[n])
      );

      a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_at(ADR_OVF) && bus_wdata[n] && !ovf_evt[n]) |=> !ovf_q[n]);

      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_evt[n] |=> ovf_q[n]);

      if ((n % 2) == 1) begin : g_chain_chk
         a_r10_chain_carry: assert property (@(posedge clk) disable iff (!rst_n)
            (carry[n-1] && gang_q[n] && run_q && en_q[n] && !val_wr[n] && !clr_all)
            |=> cval[n] == $past(cval[n]) + 1'b1);
      end
   end

   // read path, registered
   always_comb begin
      rd_mux = '0;
      for (int n = 0; n < NUM_CNT; n++) begin
         if (bus_addr == ADDR_W'(ADR_VAL_BASE + ADR_STRIDE * n)) rd_mux = DATA_W'(cval[n]);
         if (bus_addr == ADDR_W'(ADR_SEL_BASE + ADR_STRIDE * n)) rd_mux = DATA_W'(sel_q[n]);
      end
      if (bus_addr == ADDR_W'(ADR_RUN))    rd_mux = DATA_W'(run_q);
      if (bus_addr == ADDR_W'(ADR_EN_SET) || bus_addr == ADDR_W'(ADR_EN_CLR)) rd_mux = DATA_W'(en_q);
      if (bus_addr == ADDR_W'(ADR_IE_SET) || bus_addr == ADDR_W'(ADR_IE_CLR)) rd_mux = DATA_W'(ie_q);
      if (bus_addr == ADDR_W'(ADR_GANG))   rd_mux = DATA_W'(gang_q);
      if (bus_addr == ADDR_W'(ADR_OVF))    rd_mux = DATA_W'(ovf_q);
      if (bus_addr == ADDR_W'(ADR_MSB))    rd_mux = DATA_W'(msb_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q == '0) |-> !irq);

   a_r5_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      wr_at(ADR_EN_SET) |=> ((en_q & $past(bus_wdata[NUM_CNT-1:0])) == $past(bus_wdata[NUM_CNT-1:0])));

   a_r10_even_gang_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (gang_q & ~GANG_OK) == '0);

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (ovf_q == '0 && en_q == '0 && !irq));
endmodule

// File: tb/test_evt_counter_bank.sv
`timescale 1ns/1ps
module test_evt_counter_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  evt_in = '0;
   logic        irq;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_pend = 1'b0;

   always #10 clk = ~clk;

   evt_counter_bank i_evt_counter_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .irq(irq)
   );

   function automatic logic [11:0] val_a(input int n); return 12'(12'h420 + 8 * n); endfunction
   function automatic logic [11:0] sel_a(input int n); return 12'(12'h220 + 8 * n); endfunction

   task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // monitor: a read strobed at an edge is compared at the following falling edge
   always @(posedge clk) rd_pend <= bus_rd;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) compare(bus_rdata, 32'hDEADBEEF, "scoreboard underrun");
         else compare(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] pat, input int cnt);
      for (int k = 0; k < cnt; k++) begin
         @(negedge clk);
         evt_in = pat;
      end
      @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      compare({31'b0, irq}, 32'h0, "R1 irq after reset");
      rd(val_a(0), 32'h0, "R1 counter0 after reset");
      rd(12'h740, 32'h0, "R1 overflow after reset");
      rd(12'h508, 32'h0, "R1 enable mask after reset");
      rd(sel_a(3), 32'h0, "R1 selector after reset");
      // R2 unmapped reads
      rd(12'h120, 32'h0, "R2 control slot reads zero");
      rd(12'h004, 32'h0, "R2 unmapped reads zero");
      rd(12'h424, 32'h0, "R2 misaligned reads zero");

      // selectors: c0=0x20(l1) c1=0x01(l0) c2=0x7F c3=0x26(l7) c4=0x21(l2) c5=0x22(l3) c6=0x23(l4) c7=0x01
      wr(sel_a(0), 32'h20); wr(sel_a(1), 32'h01); wr(sel_a(2), 32'h7F); wr(sel_a(3), 32'h26);
      wr(sel_a(4), 32'h21); wr(sel_a(5), 32'h22); wr(sel_a(6), 32'h23); wr(sel_a(7), 32'h01);
      rd(sel_a(0), 32'h20, "R2 selector readback c0");
      rd(sel_a(2), 32'h7F, "R2 selector readback c2");
      wr(12'h508, 32'h0F);

      // R4 run bit clear: nothing moves
      pulse(8'h02, 3);
      rd(val_a(0), 32'h0, "R4 held while run bit clear");
      wr(12'h500, 32'h1);
      rd(12'h500, 32'h1, "R12 run bit readback");
      pulse(8'h02, 3);
      rd(val_a(0), 32'h3, "R4 three events counted");
      pulse(8'hFF, 2);
      rd(val_a(0), 32'h5, "R4 all lines c0");
      rd(val_a(1), 32'h2, "R3 cycles code on line 0");
      rd(val_a(2), 32'h0, "R3 unsupported code counts nothing");
      rd(val_a(3), 32'h2, "R3 code 0x26 on line 7");

      // R5 enable clear
      wr(12'h50C, 32'h01);
      rd(12'h508, 32'h0E, "R5 set address shows mask");
      rd(12'h50C, 32'h0E, "R5 clear address shows mask");
      pulse(8'h02, 2);
      rd(val_a(0), 32'h5, "R4 disabled counter holds");

      // R6 wrap, R9 irq, R8 clear
      wr(val_a(4), 32'hFFFF_FFFE);
      wr(12'h508, 32'h10);
      pulse(8'h04, 2);
      rd(val_a(4), 32'h0, "R6 wrapped to zero");
      rd(12'h740, 32'h10, "R6 wrap flags overflow");
      compare({31'b0, irq}, 32'h0, "R9 irq low without enable");
      wr(12'h510, 32'h10);
      compare({31'b0, irq}, 32'h1, "R9 irq with enable");
      rd(12'h514, 32'h10, "R5 interrupt mask readback");
      wr(12'h740, 32'h10);
      compare({31'b0, irq}, 32'h0, "R8 irq after clear");
      rd(12'h740, 32'h0, "R8 flag cleared");

      // R6 bit31 crossing without toggle option, R7 with it
      wr(val_a(4), 32'h7FFF_FFFF);
      pulse(8'h04, 1);
      rd(val_a(4), 32'h8000_0000, "R6 crossing value");
      rd(12'h740, 32'h0, "R6 no flag on bit31 rise");
      wr(12'h96C, 32'h20);
      wr(val_a(5), 32'h7FFF_FFFF);
      wr(12'h508, 32'h20);
      pulse(8'h08, 1);
      rd(12'h740, 32'h20, "R7 flag on bit31 rise");
      wr(12'h740, 32'h20);
      wr(val_a(5), 32'hFFFF_FFFF);
      pulse(8'h08, 1);
      rd(12'h740, 32'h20, "R7 flag on bit31 fall");
      rd(12'h96C, 32'h20, "R7 option readback");
      wr(12'h740, 32'hFF);

      // R8 hardware set wins over same-cycle clear
      wr(val_a(4), 32'hFFFF_FFFF);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h740; bus_wdata = 32'h10; evt_in = 8'h04;
      @(negedge clk);
      bus_wr = 1'b0; evt_in = 8'h00;
      compare({31'b0, irq}, 32'h1, "R8 set wins keeps irq");
      rd(12'h740, 32'h10, "R8 set wins over clear");
      wr(12'h740, 32'hFF);

      // R10 chaining
      wr(12'h718, 32'hC0);
      rd(12'h718, 32'h80, "R10 even gang bit dropped");
      wr(val_a(6), 32'hFFFF_FFFF);
      wr(val_a(7), 32'h5);
      wr(12'h508, 32'hC0);
      pulse(8'h10, 1);
      rd(val_a(6), 32'h0, "R10 lower wrapped");
      rd(val_a(7), 32'h6, "R10 upper took carry");
      rd(12'h740, 32'h40, "R10 lower flags wrap");
      pulse(8'h10, 1);
      rd(val_a(7), 32'h6, "R10 upper still without carry");
      pulse(8'h01, 1);
      rd(val_a(7), 32'h6, "R10 upper ignores own event");
      rd(val_a(1), 32'h3, "R4 cycles counter moved");

      // R11 software load overrides same-cycle event
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = val_a(1); bus_wdata = 32'd100; evt_in = 8'h01;
      @(negedge clk);
      bus_wr = 1'b0; evt_in = 8'h00;
      rd(val_a(1), 32'd100, "R11 load wins over event");

      // R12 clear all
      wr(12'h500, 32'h3);
      rd(12'h500, 32'h1, "R12 clear bit reads zero");
      rd(val_a(0), 32'h0, "R12 counter0 cleared");
      rd(val_a(1), 32'h0, "R12 counter1 cleared");
      rd(val_a(7), 32'h0, "R12 counter7 cleared");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) compare(32'(exp_q.size()), 32'h0, "scoreboard leftover");
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule